// File: doc/BRIEF.md
# Level-Source Interrupt Controller with Claim and Complete

This block gathers level-sensitive interrupt sources and distributes them to a parameterised number of processor targets. Every source carries a two-bit priority. Every target has its own enable mask, its own priority threshold, a claim/complete register and a software-interrupt bit. A target's interrupt line rises when at least one source meets all three conditions: it is pending, it is enabled for that target, and its priority is above that target's threshold. The handler then reads the claim register to learn which source won.

A claim takes the winning source out of arbitration for every target. The source stays out until software writes its ID back to a claim register to complete it. Several claims can be open at the same time, and software may complete them in any order. Software sets the software-interrupt bit by writing 1 to it and acknowledges it by writing 0. The bit drives a dedicated output for each target.

The registers sit on a simple synchronous bus. Read data is registered, so it appears one cycle after the read strobe. A read of a claim register also applies the claim at that same clock edge.

Top module: `irq_ctrl_top`

## Requirements
- R1: After a synchronous reset, every priority, enable mask, threshold, pending bit, claimed flag and software-interrupt bit is zero. `irq_o` and `swi_o` are low.
- R2: A source with priority 0 never raises a target's line and is never returned by a claim. A source whose priority equals the threshold is also not eligible; the priority must be strictly greater.
- R3: `irq_o[t]` is registered. It is high in the cycle after a cycle in which some source was pending, enabled for t, and above t's threshold.
- R4: Each target's enable word (word N_SRC+1+t) holds one enable bit per source, with bit s for source s. Enable bits read back as written, except bit 0, which always reads 0.
- R5: The pending word (word N_SRC) shows bit s set once source s has been sampled high while unclaimed. The bit stays set until the source is claimed, even if the input drops.
- R6: A read of target t's claim word (word N_SRC+1+N_TGT+3t+1) returns, zero-extended, the eligible source with the highest priority; on a tie the lowest ID wins. It returns 0 when no source is eligible. A non-zero result marks that source claimed and clears its pending bit.
- R7: A claimed source is never pending and is never returned by any target's claim, even while its input stays high, until it is completed.
- R8: Writing an ID to any claim word completes that source if it is claimed, and claims may be completed in any order. A write of an ID that is not claimed changes nothing.
- R9: Bit 0 of target t's software word (word N_SRC+1+N_TGT+3t+2) is set by writing 1 and cleared by writing 0. It reads back, and `swi_o[t]` follows it one cycle after the write.
- R10: Source 0 is reserved. Its priority word ignores writes and reads 0, and it never becomes pending or claimed.
- R11: Read data appears on `bus_rdata` one cycle after `bus_re`. Priorities sit at words 1..N_SRC-1 in bits [1:0]. Threshold t is at word N_SRC+1+N_TGT+3t, in bits [1:0]. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Level interrupt inputs; bit 0 is unused |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe; also triggers the claim |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | N_TGT | Per-target interrupt line |
| swi_o | output | N_TGT | Per-target software interrupt |

## Verification
The bench uses the default eight sources (seven real ones plus the reserved zero) and two targets. With this few sources, random priority, threshold and enable writes reach every priority/threshold relation, including equality and priority ties. With two targets, a source claimed through one target is checked for exclusion from the other, and a claim made through one target can be completed through the other.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int TGT_STRIDE = 3;
  typedef enum int {
    TREG_THR   = 0,
    TREG_CLAIM = 1,
    TREG_SWI   = 2
  } tgt_reg_e;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway #(
  parameter int N_SRC = 8,
  localparam int ID_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic             claim_v,
  input  logic [ID_W-1:0]  claim_id,
  input  logic             cmpl_v,
  input  logic [ID_W-1:0]  cmpl_id,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] claimed_o
);
  assign pend_o[0]    = 1'b0;
  assign claimed_o[0] = 1'b0;

  for (genvar s = 1; s < N_SRC; s++) begin : g_src
    logic pend_q, claimed_q;
    logic take, done;
    assign take = claim_v && (claim_id == ID_W'(s));
    assign done = cmpl_v && (cmpl_id == ID_W'(s));
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q    <= 1'b0;
        claimed_q <= 1'b0;
      end else if (take) begin
        pend_q    <= 1'b0;
        claimed_q <= 1'b1;
      end else begin
        if (src_i[s] && !claimed_q) pend_q <= 1'b1;
        if (done) claimed_q <= 1'b0;
      end
    end
    assign pend_o[s]    = pend_q;
    assign claimed_o[s] = claimed_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 2,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [N_SRC-1:0]             pend_i,
  input  logic [N_SRC-1:0]             en_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic                         hit_o,
  output logic [ID_W-1:0]              id_o
);
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_id;

  always_comb begin
    best_p  = '0;
    best_id = '0;
    for (int s = 1; s < N_SRC; s++) begin
      if (pend_i[s] && en_i[s] && (prio_i[s] > thr_i) && (prio_i[s] > best_p)) begin
        best_p  = prio_i[s];
        best_id = ID_W'(s);
      end
    end
  end

  assign hit_o = (best_id != '0);
  assign id_o  = best_id;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TGT  = 2,
  parameter int PRIO_W = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int ID_W  = $clog2(N_SRC)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic                         bus_re,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic [N_SRC-1:0]             pend_i,
  input  logic [N_TGT-1:0][ID_W-1:0]   win_id_i,
  output logic [N_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [N_TGT-1:0][N_SRC-1:0]  en_o,
  output logic [N_TGT-1:0][PRIO_W-1:0] thr_o,
  output logic [N_TGT-1:0]             swi_o,
  output logic                         claim_v,
  output logic [ID_W-1:0]              claim_id,
  output logic                         cmpl_v,
  output logic [ID_W-1:0]              cmpl_id
);
  localparam int PEND_IDX = N_SRC;
  localparam int EN_IDX   = N_SRC + 1;
  localparam int TGT_IDX  = N_SRC + 1 + N_TGT;

  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_TGT-1:0][N_SRC-1:0]  en_q;
  logic [N_TGT-1:0][PRIO_W-1:0] thr_q;
  logic [N_TGT-1:0]             swi_q;
  logic [DATA_W-1:0]            rdata_q, rd_mux;
  logic [N_TGT-1:0]             hit_claim;

  for (genvar t = 0; t < N_TGT; t++) begin : g_hit
    assign hit_claim[t] = (bus_addr == ADDR_W'(TGT_IDX + TGT_STRIDE*t + TREG_CLAIM));
  end

  always_comb begin
    claim_v  = 1'b0;
    claim_id = '0;
    for (int t = 0; t < N_TGT; t++) begin
      if (bus_re && hit_claim[t] && (win_id_i[t] != '0)) begin
        claim_v  = 1'b1;
        claim_id = win_id_i[t];
      end
    end
  end

  assign cmpl_v  = bus_we && (|hit_claim) && (bus_wdata < DATA_W'(N_SRC));
  assign cmpl_id = bus_wdata[ID_W-1:0];

  always_comb begin
    rd_mux = '0;
    for (int s = 1; s < N_SRC; s++)
      if (bus_addr == ADDR_W'(s)) rd_mux[PRIO_W-1:0] = prio_q[s];
    if (bus_addr == ADDR_W'(PEND_IDX)) rd_mux[N_SRC-1:0] = pend_i;
    for (int t = 0; t < N_TGT; t++) begin
      if (bus_addr == ADDR_W'(EN_IDX + t)) rd_mux[N_SRC-1:0] = en_q[t];
      if (bus_addr == ADDR_W'(TGT_IDX + TGT_STRIDE*t + TREG_THR)) rd_mux[PRIO_W-1:0] = thr_q[t];
      if (hit_claim[t]) rd_mux[ID_W-1:0] = win_id_i[t];
      if (bus_addr == ADDR_W'(TGT_IDX + TGT_STRIDE*t + TREG_SWI)) rd_mux[0] = swi_q[t];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      swi_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_we) begin
        for (int s = 1; s < N_SRC; s++)
          if (bus_addr == ADDR_W'(s)) prio_q[s] <= bus_wdata[PRIO_W-1:0];
        for (int t = 0; t < N_TGT; t++) begin
          if (bus_addr == ADDR_W'(EN_IDX + t))
            en_q[t] <= bus_wdata[N_SRC-1:0] & ~N_SRC'(1);
          if (bus_addr == ADDR_W'(TGT_IDX + TGT_STRIDE*t + TREG_THR))
            thr_q[t] <= bus_wdata[PRIO_W-1:0];
          if (bus_addr == ADDR_W'(TGT_IDX + TGT_STRIDE*t + TREG_SWI))
            swi_q[t] <= bus_wdata[0];
        end
      end
      if (bus_re) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign prio_o    = prio_q;
  assign en_o      = en_q;
  assign thr_o     = thr_q;
  assign swi_o     = swi_q;
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int N_SRC  = 8,
  parameter int N_TGT  = 2,
  parameter int PRIO_W = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TGT-1:0]  irq_o,
  output logic [N_TGT-1:0]  swi_o
);
  localparam int ID_W = $clog2(N_SRC);

  logic [N_SRC-1:0]             pend_q, claimed_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_TGT-1:0][N_SRC-1:0]  en;
  logic [N_TGT-1:0][PRIO_W-1:0] thr;
  logic [N_TGT-1:0][ID_W-1:0]   win_id;
  logic [N_TGT-1:0]             win_hit;
  logic [N_TGT-1:0]             irq_q;
  logic                         claim_v, cmpl_v;
  logic [ID_W-1:0]              claim_id, cmpl_id;

  irq_gateway #(.N_SRC(N_SRC)) u_gw (
    .clk(clk), .rst(rst), .src_i(src_i),
    .claim_v(claim_v), .claim_id(claim_id),
    .cmpl_v(cmpl_v), .cmpl_id(cmpl_id),
    .pend_o(pend_q), .claimed_o(claimed_q)
  );

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
      .prio_i(prio), .pend_i(pend_q), .en_i(en[t]), .thr_i(thr[t]),
      .hit_o(win_hit[t]), .id_o(win_id[t])
    );
  end

  irq_regfile #(
    .N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rf (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pend_i(pend_q), .win_id_i(win_id),
    .prio_o(prio), .en_o(en), .thr_o(thr), .swi_o(swi_o),
    .claim_v(claim_v), .claim_id(claim_id),
    .cmpl_v(cmpl_v), .cmpl_id(cmpl_id)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= win_hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_SRC  = 8,
  parameter int N_TGT  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_TGT-1:0]  irq_o,
  input logic [N_TGT-1:0]  swi_o,
  input logic [N_SRC-1:0]  pend_q,
  input logic [N_SRC-1:0]  claimed_q
);
  localparam int ID_W    = $clog2(N_SRC);
  localparam int TGT_IDX = N_SRC + 1 + N_TGT;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_o == '0 && swi_o == '0 && pend_q == '0 && claimed_q == '0)); // R1

  AST_CLAIMED_NOT_PENDING: assert property (@(posedge clk) disable iff (rst)
    (claimed_q & pend_q) == '0); // R7

  AST_SRC0_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (!pend_q[0] && !claimed_q[0])); // R10

  for (genvar t = 0; t < N_TGT; t++) begin : g_t
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
      irq_o[t] |-> $past(|pend_q)); // R3

    AST_SWI_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
      (bus_we && bus_addr == ADDR_W'(TGT_IDX + 3*t + 2)) |=> (swi_o[t] == $past(bus_wdata[0]))); // R9

    AST_CLAIM_MARKS: assert property (@(posedge clk) disable iff (rst)
      (bus_re && !bus_we && bus_addr == ADDR_W'(TGT_IDX + 3*t + 1))
        |=> (bus_rdata == '0 || (bus_rdata < DATA_W'(N_SRC) && claimed_q[bus_rdata[ID_W-1:0]]))); // R6
  end
endmodule

bind irq_ctrl_top irq_ctrl_chk #(
  .N_SRC(N_SRC), .N_TGT(N_TGT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o), .swi_o(swi_o),
  .pend_q(pend_q), .claimed_q(claimed_q)
);

// File: tb/sim_irq_ctrl_top.sv
`timescale 1ns/1ps
module sim_irq_ctrl_top;
  localparam int NS = 8;
  localparam int NT = 2;
  localparam int PEND = NS;
  localparam int ENB = NS + 1;
  localparam int TGB = NS + 1 + NT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] src_i = '0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NT-1:0] irq_o, swi_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int m_prio[NS];
  int m_en[NT];
  int m_thr[NT];
  bit m_swi[NT];
  bit m_pend[NS];
  bit m_clm[NS];

  always #10 clk = ~clk;

  irq_ctrl_top u0 (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .swi_o(swi_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_win(input int t);
    int bp = 0, bi = 0;
    for (int s = 1; s < NS; s++)
      if (m_pend[s] && m_en[t][s] && m_prio[s] > m_thr[t] && m_prio[s] > bp) begin
        bp = m_prio[s];
        bi = s;
      end
    return bi;
  endfunction

  function automatic int m_read(input int a);
    int v = 0;
    if (a >= 1 && a < NS) v = m_prio[a];
    if (a == PEND) for (int s = 0; s < NS; s++) v[s] = m_pend[s];
    for (int t = 0; t < NT; t++) begin
      if (a == ENB + t) v = m_en[t];
      if (a == TGB + 3*t) v = m_thr[t];
      if (a == TGB + 3*t + 1) v = m_win(t);
      if (a == TGB + 3*t + 2) v = int'(m_swi[t]);
    end
    return v;
  endfunction

  function automatic void m_reset();
    for (int s = 0; s < NS; s++) begin m_prio[s] = 0; m_pend[s] = 0; m_clm[s] = 0; end
    for (int t = 0; t < NT; t++) begin m_en[t] = 0; m_thr[t] = 0; m_swi[t] = 0; end
  endfunction

  // one bus cycle with lock-step model update and output checks
  task automatic op(input bit we, input bit re, input int a, input int wd, input string tag);
    int exp_rd, cid, did;
    bit [NT-1:0] exp_irq;
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = 8'(a); bus_wdata = 32'(wd);
    exp_rd = m_read(a);
    cid = 0; did = 0;
    for (int t = 0; t < NT; t++) begin
      exp_irq[t] = (m_win(t) != 0);
      if (re && a == TGB + 3*t + 1) cid = m_win(t);
      if (we && a == TGB + 3*t + 1 && wd >= 0 && wd < NS) did = wd;
    end
    for (int s = 1; s < NS; s++) begin
      if (cid == s) begin m_clm[s] = 1; m_pend[s] = 0; end
      else begin
        if (src_i[s] && !m_clm[s]) m_pend[s] = 1;
        if (did == s) m_clm[s] = 0;
      end
    end
    if (we) begin
      if (a >= 1 && a < NS) m_prio[a] = wd & 3;
      for (int t = 0; t < NT; t++) begin
        if (a == ENB + t) m_en[t] = wd & ((1 << NS) - 2);
        if (a == TGB + 3*t) m_thr[t] = wd & 3;
        if (a == TGB + 3*t + 2) m_swi[t] = wd[0];
      end
    end
    @(posedge clk); #1;
    bus_we = 1'b0; bus_re = 1'b0;
    if (re) chk(tag, int'(bus_rdata), exp_rd);
    chk("R3 irq_o", int'(irq_o), int'(exp_irq));
    for (int t = 0; t < NT; t++) chk("R9 swi_o", int'(swi_o[t]), int'(m_swi[t]));
  endtask

  task automatic wr(input int a, input int d, input string tag); op(1, 0, a, d, tag); endtask
  task automatic rd(input int a, input string tag); op(0, 1, a, 0, tag); endtask
  task automatic idle(); op(0, 0, 0, 0, "idle"); endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r, a, w;
    void'($urandom(32'd4242));
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq_o reset", int'(irq_o), 0);
    chk("R1 swi_o reset", int'(swi_o), 0);
    @(negedge clk); rst = 1'b0;
    // R1 / R11: every word reads zero after reset
    for (int i = 0; i < TGB + 3*NT + 2; i++) rd(i, "R1 R11 reset readback");

    // R10: source 0 reserved
    src_i[0] = 1'b1;
    wr(0, 3, "R10");
    rd(0, "R10 prio0 reads 0");
    idle();
    rd(PEND, "R10 src0 never pending");
    wr(ENB, 32'hFF, "R4");
    rd(ENB, "R4 enable readback bit0 clear");

    // R2: priority 0 / equality with threshold
    src_i[3] = 1'b1;
    idle(); idle();
    rd(PEND, "R5 pending set");
    wr(TGB, 2, "R2");
    wr(3, 2, "R2");
    idle(); idle();
    chk("R2 prio equal thr no irq", int'(irq_o[0]), 0);
    wr(TGB, 1, "R3");
    idle();
    chk("R3 irq after thr drop", int'(irq_o[0]), 1);
    wr(TGB, 0, "R2");
    wr(3, 0, "R2");
    idle();
    chk("R2 prio0 no irq", int'(irq_o[0]), 0);
    rd(TGB + 1, "R2 claim of prio0 gives 0");

    // R6 tie: sources 2 and 5 at priority 3
    wr(3, 1, "R6");
    wr(2, 3, "R6"); wr(5, 3, "R6");
    src_i[2] = 1'b1; src_i[5] = 1'b1;
    idle(); idle();
    rd(TGB + 1, "R6 tie lowest id");
    chk("R6 tie wins 2", int'(bus_rdata), 2);
    src_i[3] = 1'b0;
    rd(PEND, "R5 pending sticky after input drops");
    wr(ENB + 1, 32'hFF, "R4");
    rd(TGB + 4, "R7 other target skips claimed");
    chk("R7 t1 gets 5", int'(bus_rdata), 5);
    rd(TGB + 1, "R6 next best");
    chk("R6 t0 gets 3", int'(bus_rdata), 3);
    rd(TGB + 1, "R6 nothing left");
    chk("R6 empty claim 0", int'(bus_rdata), 0);
    // R8: ignore unclaimed, complete out of order
    wr(TGB + 1, 4, "R8 unclaimed ignored");
    wr(TGB + 1, 2, "R8");
    idle();
    rd(TGB + 1, "R8 after completing 2");
    chk("R8 reclaim 2", int'(bus_rdata), 2);
    wr(TGB + 4, 3, "R8");
    wr(TGB + 1, 5, "R8");
    wr(TGB + 1, 2, "R8");
    idle(); idle();
    rd(PEND, "R8 pending after completes");

    // R9 software interrupt
    wr(TGB + 2, 1, "R9"); rd(TGB + 2, "R9 set readback");
    wr(TGB + 5, 1, "R9"); wr(TGB + 2, 0, "R9");
    rd(TGB + 2, "R9 clear readback");
    wr(TGB + 5, 0, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (i % 16 == 0) src_i = NS'($urandom);
      r = int'($urandom_range(0, 9));
      a = int'($urandom_range(0, TGB + 3*NT + 1));
      w = int'($urandom_range(0, 255));
      if (r < 3) wr(a, w, "R11 random write");
      else if (r < 6) rd(a, "R11 random read");
      else if (r < 8) rd(TGB + 3*int'($urandom_range(0, NT-1)) + 1, "R6 random claim");
      else if (r < 9) wr(TGB + 3*int'($urandom_range(0, NT-1)) + 1, int'($urandom_range(0, NS-1)), "R8 random complete");
      else idle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule